// File: doc/BRIEF.md
# Adjacent-Pair One-Hot Error Checker

This block watches the state vector of a token-passing control network in which exactly one stage should hold the token at any time. The connection graph of the network is a parameter: a square bit matrix that records, for every stage, which stages it can hand the token to. The checker combines three kinds of error. An empty network can be flagged, and that test can be switched off because the network is legitimately empty between runs. Two live stages that share a direct link can be flagged. As an alternative, an even count of live stages can be flagged with a parity tree. Any error is latched into a sticky flag that only reset clears.

The pair check comes in two structural variants, chosen by a parameter. The exact variant builds one two-input AND for each non-self link. The split variant is for graphs whose links mostly join an even-numbered stage to an odd-numbered one. It ANDs the OR of all even bits with the OR of all odd bits, and then adds one extra two-input AND for each link that joins two stages of the same parity. The split variant costs fewer gates. In exchange, it also flags any live even stage together with any live odd stage, whether or not the two are linked.

Top module: `adjpair_onehot_chk`

## Requirements
- R1: A synchronous active-high `rst` clears `err_flag` to 0 at the next rising clock edge.
- R2: When `zero_en` is 1, an all-zero `state` sets the flag in both modes. When `zero_en` is 0, an all-zero `state` has no effect.
- R3: In pair mode (`chk_mode` = 0), two live stages i and j with a link from i to j (i ≠ j) set the flag. Bit i*N+j of `LINKS` marks the link from stage i to stage j. The default graph has N=8, a ring i→(i+1) mod 8, a self link on stage 3, and extra links 2→4 and 5→1.
- R4: In the exact variant, two live stages with no link between them do not set the flag. In every variant and mode, a single live stage never sets the flag.
- R5: Self links create no pair gate, so stage 3 alone stays error-free.
- R6: In the split variant, pair mode flags any live even stage together with any live odd stage. It also flags both ends of every same-parity link (2→4, 5→1). Two same-parity stages without a link (for example 0 and 2, or 1 and 3) are not flagged.
- R7: In parity mode (`chk_mode` = 1), a nonzero even count of live stages sets the flag, and an odd count does not. The parity is taken through a chain of N-1 XOR gates.
- R8: An error present on the inputs before a rising edge is visible on `err_flag` right after that edge. The flag then stays at 1 until reset, even when later vectors are clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the flag |
| chk_mode | input | 1 | 0 = linked-pair check, 1 = even-parity check |
| zero_en | input | 1 | Enables the empty-network error |
| state | input | N | Stage activity vector, bit k = stage k live |
| err_flag | output | 1 | Sticky error flag |

## Verification
The bench compares an exact-variant instance and a split-variant instance on the same stimulus, so that their one intended difference is observed directly. Stages 0 and 3 are live together but unlinked: a split variant that fails to flag them, or an exact variant that does flag them, is exposed. Same-parity links and unlinked same-parity pairs are driven to catch extra gates that are missing or misplaced. In parity mode, two-bit, three-bit and four-bit vectors catch an inverted or truncated XOR chain. Clean vectors that follow an error catch a flag that does not hold, and a lone self-linked stage catches a spurious self-pair gate.

// File: rtl/onehot_chk_pkg.sv
package onehot_chk_pkg;

    localparam int MAX_N = 32;

    typedef enum logic {
        CHK_PAIR   = 1'b0,
        CHK_PARITY = 1'b1
    } chk_mode_e;

    // Default link matrix: ring plus one self link and two same-parity links.
    function automatic logic [MAX_N*MAX_N-1:0] ring_links(int n);
        logic [MAX_N*MAX_N-1:0] v;
        v = '0;
        for (int i = 0; i < n; i++) begin
            v[i*n + ((i + 1) % n)] = 1'b1;
        end
        if (n > 5) begin
            v[3*n + 3] = 1'b1;
            v[2*n + 4] = 1'b1;
            v[5*n + 1] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/zero_detect.sv
module zero_detect #(
    parameter int N = 8
) (
    input  logic [N-1:0] state,
    input  logic         enable,
    output logic         empty_hit
);
    always_comb empty_hit = enable & ~(|state);
endmodule

// File: rtl/parity_chain.sv
module parity_chain #(
    parameter int N = 8
) (
    input  logic [N-1:0] state,
    output logic         even_hit
);
    logic [N-1:0] acc;

    assign acc[0] = state[0];
    for (genvar k = 1; k < N; k++) begin : g_xor
        assign acc[k] = acc[k-1] ^ state[k];
    end

    always_comb even_hit = ~acc[N-1] & (|state);
endmodule

// File: rtl/pair_net.sv
module pair_net #(
    parameter int             N          = 8,
    parameter logic [N*N-1:0] LINKS      = '0,
    parameter bit             SPLIT_FORM = 1'b1
) (
    input  logic [N-1:0] state,
    output logic         pair_hit
);
    logic [N*N-1:0] gate_v;

    if (SPLIT_FORM) begin : g_split
        logic [N-1:0] even_bits;
        logic [N-1:0] odd_bits;
        for (genvar k = 0; k < N; k++) begin : g_cls
            assign even_bits[k] = (k % 2 == 0) ? state[k] : 1'b0;
            assign odd_bits[k]  = (k % 2 == 1) ? state[k] : 1'b0;
        end
        for (genvar i = 0; i < N; i++) begin : g_row
            for (genvar j = 0; j < N; j++) begin : g_col
                if (LINKS[i*N+j] && i != j && (i % 2) == (j % 2)) begin : g_same
                    assign gate_v[i*N+j] = state[i] & state[j];
                end else begin : g_none
                    assign gate_v[i*N+j] = 1'b0;
                end
            end
        end
        always_comb pair_hit = ((|even_bits) & (|odd_bits)) | (|gate_v);
    end else begin : g_exact
        for (genvar i = 0; i < N; i++) begin : g_row
            for (genvar j = 0; j < N; j++) begin : g_col
                if (LINKS[i*N+j] && i != j) begin : g_link
                    assign gate_v[i*N+j] = state[i] & state[j];
                end else begin : g_none
                    assign gate_v[i*N+j] = 1'b0;
                end
            end
        end
        always_comb pair_hit = |gate_v;
    end
endmodule

// File: rtl/adjpair_onehot_chk.sv
module adjpair_onehot_chk
    import onehot_chk_pkg::*;
#(
    parameter int             N          = 8,
    parameter logic [N*N-1:0] LINKS      = (N*N)'(ring_links(N)),
    parameter bit             SPLIT_FORM = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         chk_mode,
    input  logic         zero_en,
    input  logic [N-1:0] state,
    output logic         err_flag
);
    chk_mode_e mode_q;
    logic      empty_hit, pair_hit, even_hit, err_now;

    always_comb mode_q = chk_mode_e'(chk_mode);

    zero_detect #(.N(N)) u_zero (
        .state(state), .enable(zero_en), .empty_hit(empty_hit)
    );

    pair_net #(.N(N), .LINKS(LINKS), .SPLIT_FORM(SPLIT_FORM)) u_pair (
        .state(state), .pair_hit(pair_hit)
    );

    parity_chain #(.N(N)) u_par (
        .state(state), .even_hit(even_hit)
    );

    always_comb begin
        err_now = empty_hit;
        case (mode_q)
            CHK_PAIR:   err_now = err_now | pair_hit;
            CHK_PARITY: err_now = err_now | even_hit;
            default:    err_now = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          err_flag <= 1'b0;
        else if (err_now) err_flag <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !err_flag);
    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);
    // R2
    empty_set_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_en && state == '0) |=> err_flag);
    // R2
    empty_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!zero_en && state == '0 && !err_flag) |=> !err_flag);
    // R3
    pair_set_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == CHK_PAIR && pair_hit) |=> err_flag);
    // R4
    single_clean_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(state) == 1 && !err_flag) |=> !err_flag);
    // R7
    parity_set_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == CHK_PARITY && state != '0 && ($countones(state) % 2) == 0)
        |=> err_flag);
endmodule

// File: tb/adjpair_onehot_chk_test.sv
module adjpair_onehot_chk_test;

    typedef struct {
        logic  exp_s;
        logic  exp_x;
        int    due;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chk_mode = 1'b0;
    logic       zero_en = 1'b1;
    logic [7:0] state = 8'h00;
    logic       flag_s, flag_x;

    int    cyc = 0;
    int    n_vec = 0;
    int    n_bad = 0;
    logic  mdl_s = 1'b0;
    logic  mdl_x = 1'b0;
    bit    done = 1'b0;
    item_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adjpair_onehot_chk uut (
        .clk(clk), .rst(rst), .chk_mode(chk_mode), .zero_en(zero_en),
        .state(state), .err_flag(flag_s)
    );

    adjpair_onehot_chk #(.SPLIT_FORM(1'b0)) uut_x (
        .clk(clk), .rst(rst), .chk_mode(chk_mode), .zero_en(zero_en),
        .state(state), .err_flag(flag_x)
    );

    function automatic bit linked(int i, int j);
        return (j == (i + 1) % 8) || (i == 3 && j == 3) ||
               (i == 2 && j == 4) || (i == 5 && j == 1);
    endfunction

    function automatic bit exact_pair(logic [7:0] s);
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                if (i != j && linked(i, j) && s[i] && s[j]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit split_pair(logic [7:0] s);
        return ((|(s & 8'h55)) && (|(s & 8'hAA))) ||
               (s[2] && s[4]) || (s[5] && s[1]);
    endfunction

    function automatic bit expect_err(logic [7:0] s, logic md, logic ze, bit split);
        bit e;
        e = ze && (s == 8'h00);
        if (md == 1'b0) e = e || (split ? split_pair(s) : exact_pair(s));
        else            e = e || (s != 8'h00 && ($countones(s) % 2) == 0);
        return e;
    endfunction

    task automatic check(string tag, logic got, logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic apply(logic [7:0] s, logic md, logic ze, bit do_rst, string tag);
        item_t it;
        @(negedge clk);
        if (do_rst) begin
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            mdl_s = 1'b0;
            mdl_x = 1'b0;
        end
        state = s;
        chk_mode = md;
        zero_en = ze;
        mdl_s = mdl_s | expect_err(s, md, ze, 1'b1);
        mdl_x = mdl_x | expect_err(s, md, ze, 1'b0);
        it.exp_s = mdl_s;
        it.exp_x = mdl_x;
        it.due = cyc + 1;
        it.tag = tag;
        q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            if (q.size() > 0 && cyc >= q[0].due) begin
                it = q.pop_front();
                check({it.tag, " split"}, flag_s, it.exp_s);
                check({it.tag, " exact"}, flag_x, it.exp_x);
            end
        end
    end

    initial begin : watchdog
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : driver
        state = 8'h01;
        repeat (3) @(negedge clk);
        check("R1 reset split", flag_s, 1'b0);
        check("R1 reset exact", flag_x, 1'b0);
        rst = 1'b0;

        apply(8'h01, 1'b0, 1'b1, 1'b1, "R4 single stage 0");
        apply(8'h08, 1'b0, 1'b1, 1'b1, "R5 self-linked stage 3");
        apply(8'h00, 1'b0, 1'b1, 1'b1, "R2 empty enabled pair");
        apply(8'h00, 1'b0, 1'b0, 1'b1, "R2 empty disabled pair");
        apply(8'h00, 1'b1, 1'b1, 1'b1, "R2 empty enabled parity");
        apply(8'h00, 1'b1, 1'b0, 1'b1, "R2 empty disabled parity");
        apply(8'h03, 1'b0, 1'b1, 1'b1, "R3 ring link 0-1");
        apply(8'h81, 1'b0, 1'b1, 1'b1, "R3 ring link 7-0");
        apply(8'h14, 1'b0, 1'b1, 1'b1, "R6 same-parity link 2-4");
        apply(8'h22, 1'b0, 1'b1, 1'b1, "R6 same-parity link 5-1");
        apply(8'h05, 1'b0, 1'b1, 1'b1, "R6 unlinked even pair 0-2");
        apply(8'h0A, 1'b0, 1'b1, 1'b1, "R6 unlinked odd pair 1-3");
        apply(8'h09, 1'b0, 1'b1, 1'b1, "R4 unlinked mixed pair 0-3");
        apply(8'h15, 1'b0, 1'b1, 1'b1, "R3 three live 0-2-4");
        apply(8'h03, 1'b1, 1'b1, 1'b1, "R7 parity two live");
        apply(8'h07, 1'b1, 1'b1, 1'b1, "R7 parity three live");
        apply(8'h0F, 1'b1, 1'b1, 1'b1, "R7 parity four live");
        apply(8'h80, 1'b1, 1'b1, 1'b1, "R7 parity single live");
        apply(8'h05, 1'b1, 1'b1, 1'b1, "R7 parity unlinked pair");
        apply(8'h03, 1'b0, 1'b1, 1'b1, "R8 error captured");
        apply(8'h04, 1'b0, 1'b1, 1'b0, "R8 held after clean vector");
        apply(8'h10, 1'b1, 1'b1, 1'b0, "R8 held across mode change");
        apply(8'h02, 1'b0, 1'b1, 1'b1, "R1 cleared by reset");

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule